// File: doc/BRIEF.md
# Receive Word Queue with Status Flags and Interrupt Mask

This block buffers words that arrive from the card side of a storage-card host controller and hands them to the system bus. It holds up to 32 words of 32 bits each. The card-side data path pushes words through a valid/ready stream port. Software, or a DMA engine, pops the oldest word by reading the data register through a simple single-clock register strobe interface.

The block derives live occupancy flags from the fill count: full, empty, data-available and a fixed 8-word threshold. The threshold flag also drives a DMA request pin. A sticky overrun flag records any word that is lost. A mask register chooses which flags can raise the interrupt line, and a clear register resets the sticky flag.

Back-pressure on the stream port works as follows. `in_ready` is low only while the queue is full, and a word is accepted on any cycle where `in_valid` and `in_ready` are both high. The card side cannot be stalled. A word presented while `in_ready` is low is dropped and counts as an overrun, even if a pop happens in the same cycle.

Top module: `rx_word_queue`

## Requirements
- R1: The queue stores up to 32 words. `in_ready` is low, and status bit 0 (full) is 1, exactly when 32 words are held.
- R2: Status bit 1 (empty) is 1 when no word is held. Status bit 3 (data available) is always its inverse.
- R3: Status bit 2 (threshold) and the `dma_req` output are 1 whenever 8 or more words are held.
- R4: When `in_valid` is high while the queue is full, the word is discarded, the stored words and their order are unchanged, and status bit 4 (overrun) is set on the next cycle.
- R5: Writing the clear register (address 3) with bit 4 set clears the overrun flag. Writing it with bit 4 at 0 has no effect. An overrun in the same cycle as a clear leaves the flag set.
- R6: `irq` is a registered OR of (status bits AND mask bits). It follows a flag or mask change one cycle later.
- R7: A push and a pop in the same cycle on a queue that is neither empty nor full leave the occupancy unchanged.
- R8: A data register read (address 0) while empty returns zero and changes no state.
- R9: After reset the queue is empty, overrun is clear, the mask is zero, `irq` and `dma_req` are low, and `in_ready` is high.
- R10: A data register read returns the oldest stored word and removes it, so words leave in arrival order.
- R11: The mask register (address 2, bits 4:0) is written by `reg_wr` and reads back its value. The status register is at address 1, and address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Card-side word present |
| in_ready | output | 1 | Queue can accept a word (not full) |
| in_data | input | 32 | Card-side word |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of address 0 pops) |
| reg_addr | input | 2 | Register select: 0 data, 1 status, 2 mask, 3 clear |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the selected address (combinational) |
| dma_req | output | 1 | Threshold reached (8 or more words) |
| irq | output | 1 | Registered masked interrupt request |

## Verification
Some properties are checked by assertions on every cycle:
- the occupancy never goes past 32 or below zero;
- a matched push and pop holds the count;
- a dropped word sets the overrun flag and leaves the queue full;
- the overrun flag stays set until a clear arrives;
- an empty data read returns zero;
- a mask write lands in the mask register.

Other behaviours only the bench scenarios can show, by comparing against a queue-based model on every clock:
- arrival order is kept across a drop;
- set wins over clear when both happen in the same cycle;
- a zero clear write has no effect;
- `irq` lags a flag or mask change by exactly one cycle.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  // Register addresses decoded by the strobe interface
  typedef enum logic [1:0] {
    RXQ_DATA = 2'd0,
    RXQ_STAT = 2'd1,
    RXQ_MASK = 2'd2,
    RXQ_CLR  = 2'd3
  } rxq_reg_e;

  // Status bit positions (also used by mask and clear registers)
  localparam int ST_FULL  = 0;
  localparam int ST_EMPTY = 1;
  localparam int ST_THR   = 2;
  localparam int ST_AVAIL = 3;
  localparam int ST_OVR   = 4;
  localparam int NFLAGS   = 5;
endpackage

// File: rtl/rxq_storage.sv
module rxq_storage #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    count
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr;
  logic [AW-1:0]    rd_ptr;

  function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= step_ptr(wr_ptr);
      if (pop)  rd_ptr <= step_ptr(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  assign head = mem[rd_ptr];

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count < CW'(DEPTH)));

  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0));

  // R7
  push_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> (count == $past(count)));
endmodule

// File: rtl/rxq_flags.sv
module rxq_flags
  import rxq_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int THRESH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW-1:0]     count,
  input  logic              drop,
  input  logic              clr_ovr,
  input  logic [NFLAGS-1:0] mask,
  output logic [NFLAGS-1:0] flags,
  output logic              irq
);
  logic ovr_q;
  logic irq_q;

  // Set has priority over clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovr_q <= 1'b0;
    else if (drop)    ovr_q <= 1'b1;
    else if (clr_ovr) ovr_q <= 1'b0;
  end

  always_comb begin
    flags           = '0;
    flags[ST_FULL]  = (count == CW'(DEPTH));
    flags[ST_EMPTY] = (count == '0);
    flags[ST_THR]   = (count >= CW'(THRESH));
    flags[ST_AVAIL] = (count != '0);
    flags[ST_OVR]   = ovr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(flags & mask);
  end

  assign irq = irq_q;

  // R4
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> flags[ST_OVR]);

  // R5
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[ST_OVR] && !clr_ovr) |=> flags[ST_OVR]);

  // R6
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(mask) != '0));
endmodule

// File: rtl/rxq_regs.sv
module rxq_regs
  import rxq_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [WIDTH-1:0]  reg_wdata,
  input  logic [WIDTH-1:0]  head,
  input  logic [NFLAGS-1:0] flags,
  output logic [NFLAGS-1:0] mask,
  output logic              pop,
  output logic              clr_ovr,
  output logic [WIDTH-1:0]  reg_rdata
);
  rxq_reg_e sel;
  assign sel = rxq_reg_e'(reg_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           mask <= '0;
    else if (reg_wr && sel == RXQ_MASK)   mask <= reg_wdata[NFLAGS-1:0];
  end

  assign pop     = reg_rd && (sel == RXQ_DATA) && flags[ST_AVAIL];
  assign clr_ovr = reg_wr && (sel == RXQ_CLR) && reg_wdata[ST_OVR];

  always_comb begin
    case (sel)
      RXQ_DATA: reg_rdata = flags[ST_AVAIL] ? head : '0;
      RXQ_STAT: reg_rdata = WIDTH'(flags);
      RXQ_MASK: reg_rdata = WIDTH'(mask);
      default:  reg_rdata = '0;
    endcase
  end

  // R8
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && sel == RXQ_DATA && flags[ST_EMPTY]) |-> (reg_rdata == '0 && !pop));

  // R11
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && sel == RXQ_MASK) |=> (mask == $past(reg_wdata[NFLAGS-1:0])));
endmodule

// File: rtl/rx_word_queue.sv
module rx_word_queue
  import rxq_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int DEPTH  = 32,
  parameter int THRESH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [1:0]       reg_addr,
  input  logic [WIDTH-1:0] reg_wdata,
  output logic [WIDTH-1:0] reg_rdata,
  output logic             dma_req,
  output logic             irq
);
  logic [CW-1:0]     count;
  logic [WIDTH-1:0]  head;
  logic [NFLAGS-1:0] flags;
  logic [NFLAGS-1:0] mask;
  logic              push, pop, drop, clr_ovr;

  assign in_ready = !flags[ST_FULL];
  assign push     = in_valid && in_ready;
  assign drop     = in_valid && !in_ready;
  assign dma_req  = flags[ST_THR];

  rxq_storage #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .wdata(in_data), .head(head), .count(count)
  );

  rxq_flags #(.DEPTH(DEPTH), .THRESH(THRESH)) u_flags (
    .clk(clk), .rst_n(rst_n), .count(count), .drop(drop),
    .clr_ovr(clr_ovr), .mask(mask), .flags(flags), .irq(irq)
  );

  rxq_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .head(head),
    .flags(flags), .mask(mask), .pop(pop), .clr_ovr(clr_ovr),
    .reg_rdata(reg_rdata)
  );

  // R4
  drop_stays_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !pop) |=> !in_ready);
endmodule

// File: tb/rx_word_queue_tb.sv
`timescale 1ns/1ps
module rx_word_queue_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dma_req;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rx_word_queue u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_req(dma_req), .irq(irq)
  );

  // Behavioural reference model
  logic [31:0] q[$];
  bit          m_ovr = 0;
  logic [4:0]  m_mask = '0;
  bit          m_irq = 0;

  function automatic logic [4:0] m_status();
    logic [4:0] s;
    s[0] = (q.size() == 32);
    s[1] = (q.size() == 0);
    s[2] = (q.size() >= 8);
    s[3] = (q.size() != 0);
    s[4] = m_ovr;
    return s;
  endfunction

  function automatic logic [31:0] m_read(input logic [1:0] a);
    case (a)
      2'd0:    return (q.size() != 0) ? q[0] : 32'd0;
      2'd1:    return {27'd0, m_status()};
      2'd2:    return {27'd0, m_mask};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // One clock: drive at negedge, check read data, update model, compare outputs
  task automatic cycle(input bit v, input logic [31:0] d, input bit wr, input bit rd,
                       input logic [1:0] a, input logic [31:0] wd);
    logic [4:0] st;
    bit full_pre;
    in_valid = v; in_data = d; reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
    #1;
    if (rd) begin
      case (a)
        2'd0:    chk("R8 R10 data read", reg_rdata, m_read(a));
        2'd1:    chk("R1 R2 R3 R4 status read", reg_rdata, m_read(a));
        2'd2:    chk("R11 mask read", reg_rdata, m_read(a));
        default: chk("R11 clear addr read", reg_rdata, m_read(a));
      endcase
    end
    @(posedge clk);
    st = m_status();
    full_pre = (q.size() == 32);
    if (rd && a == 2'd0 && q.size() != 0) void'(q.pop_front());
    if (v && !full_pre) q.push_back(d);
    if (wr && a == 2'd3 && wd[4]) m_ovr = 0;
    if (v && full_pre) m_ovr = 1;
    m_irq = |(st & m_mask);
    if (wr && a == 2'd2) m_mask = wd[4:0];
    @(negedge clk);
    chk("R1 in_ready", {31'd0, in_ready}, {31'd0, q.size() != 32});
    chk("R3 dma_req", {31'd0, dma_req}, {31'd0, q.size() >= 8});
    chk("R6 irq", {31'd0, irq}, {31'd0, m_irq});
  endtask

  task automatic idle();                      cycle(0, 0, 0, 0, 2'd0, 0); endtask
  task automatic push(input logic [31:0] d);  cycle(1, d, 0, 0, 2'd0, 0); endtask
  task automatic rd(input logic [1:0] a);     cycle(0, 0, 0, 1, a, 0);    endtask
  task automatic wr(input logic [1:0] a, input logic [31:0] w); cycle(0, 0, 1, 0, a, w); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R9 reset state
    chk("R9 in_ready after reset", {31'd0, in_ready}, 32'd1);
    chk("R9 dma_req after reset", {31'd0, dma_req}, 32'd0);
    chk("R9 irq after reset", {31'd0, irq}, 32'd0);
    @(negedge clk);
    rd(2'd1);                       // R9: status 0x02
    rd(2'd2);                       // R9 R11: mask zero
    rd(2'd3);                       // R11: clear address reads zero
    // R6: mask data-available then push one word
    wr(2'd2, 32'h08);
    rd(2'd2);
    push(32'hA000_0001);
    idle();
    for (int i = 2; i <= 5; i++) push(32'hA000_0000 + i);
    rd(2'd1);
    // R10: drain in order
    for (int i = 0; i < 5; i++) rd(2'd0);
    // R8: empty reads
    rd(2'd0); rd(2'd0); rd(2'd1);
    // R3: fill through the threshold to 31
    for (int i = 0; i < 31; i++) push(32'hB000_0000 + i);
    rd(2'd1);
    // R7: push and pop together
    for (int i = 0; i < 4; i++) cycle(1, 32'hC000_0000 + i, 0, 1, 2'd0, 0);
    rd(2'd1);
    push(32'hD000_0000);            // R1: now full
    rd(2'd1);
    // R4: overrun, word dropped
    wr(2'd2, 32'h10);
    push(32'hDEAD_0001);
    push(32'hDEAD_0002);
    rd(2'd1);
    // R5: zero clear ignored, set beats clear, plain clear works
    wr(2'd3, 32'h0000_000F);
    rd(2'd1);
    cycle(1, 32'hDEAD_0003, 1, 0, 2'd3, 32'h10);
    rd(2'd1);
    wr(2'd3, 32'h10);
    rd(2'd1);
    idle();
    // R4 R10: contents unchanged after drops
    for (int i = 0; i < 32; i++) rd(2'd0);
    rd(2'd1);
    // Mixed traffic
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      cycle(r[0] | r[1], $urandom, r[2] & r[3], r[4] | r[5], r[7:6], {27'd0, r[12:8]});
    end
    rd(2'd1);
    done = 1;
    summary();
  end
endmodule